// File: doc/BRIEF.md
# Configuration Port Unlock and Register File

This block sits on a simple host I/O bus that carries 8-bit writes and reads, each with a port address. It models the plug-and-play configuration front end of a legacy peripheral controller. After reset it is locked. It listens on the primary configuration port for a four-byte unlock key, and the last byte of the key picks one of two base addresses. Once it is unlocked, the host selects a register by writing the base port (the index) and then reads or writes that register through base+1 (the data port).

The registers are either global or held per logical device. A global register holds the logical device number, and the per-device activate register applies to the device it names. Other global registers select which chip is being configured (by comparison with a strap pin), drive a clock-select output and hold a software-suspend flag. A write-only control register returns the block to the locked state.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked. `cfg_active`, every bit of `dev_enable`, `clk_sel_24m` and `soft_suspend` are 0, and reads of ports 0x2E and 0x2F return 0xFF.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in order to port 0x2E while locked unlocks the block at base 0x2E. The index port is then 0x2E and the data port is 0x2F, and `cfg_active` is 1 from the cycle after the fourth write.
- R3: If the fourth key byte is 0xAA, the block unlocks at base 0x4E, with the data port at 0x4F. Reads of 0x2E and 0x2F then return 0xFF.
- R4: A write to port 0x2E that does not match the expected key byte restarts the matcher. If that byte is 0x87, it counts as a new first byte. Writes to other ports leave the matcher unchanged.
- R5: While locked, reads of the index and data ports return 0xFF, and writes to them change no register. This includes the index, which is kept across lock and unlock.
- R6: Once unlocked, a read of the index port returns the last index written. A data access reaches the register that the index names. Unimplemented indices read 0x00 and ignore writes.
- R7: Register 0x07 holds the logical device number and reads back in full. When it is NUM_DEV or more, writes to 0x30 change no enable, and 0x30 reads 0x00.
- R8: Writing register 0x30 sets bit `n` of `dev_enable` to data bit 0, where `n` is the logical device number. Register 0x30 reads back that bit in bit 0, with the upper bits 0.
- R9: A data write with bit 1 set to register 0x02 locks the block from the next cycle. A write to 0x02 with bit 1 clear has no effect, and 0x02 reads 0xFF.
- R10: Bit 7 of register 0x22 is compared with `chip_strap`. Once 0x22 has been written and the bit differs from the strap, data writes to other registers are dropped and data reads return 0xFF. Writes to 0x22 and 0x02 are always taken, and until 0x22 is written every write is taken. Register 0x22 reads as {bit7, 7'b0}.
- R11: Bit 0 of register 0x24 drives `clk_sel_24m`, and bit 0 of register 0x23 drives `soft_suspend`. Both registers read back that bit in bit 0.
- R12: When a read and a write fall on the same port in the same cycle, the read returns the value before the write. The write takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Port address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0xFF when not claimed |
| chip_strap | input | 1 | Strap compared with bit 7 of register 0x22 |
| dev_enable | output | NUM_DEV | Activate bit per logical device |
| clk_sel_24m | output | 1 | Clock-select bit from register 0x24 |
| soft_suspend | output | 1 | Suspend flag from register 0x23 |
| cfg_active | output | 1 | High while unlocked |

## Verification
The bus allows a read and a write in the same cycle. The bench drives both strobes together on the data port while the activate register is selected. It then checks that the read data shows the enable from before the edge, and that `dev_enable` shows the new value one cycle later. A second concern is the key matcher restarting at the moment a byte breaks the sequence. The bench sends a repeated 0x87, 0x01 prefix and then a sequence broken by a foreign byte. It judges the result by `cfg_active` and by the read-back at the base port.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam int KEY_LEN = 4;
   localparam logic [7:0] KEY_BYTE0    = 8'h87;
   localparam logic [7:0] KEY_BYTE1    = 8'h01;
   localparam logic [7:0] KEY_BYTE2    = 8'h55;
   localparam logic [7:0] KEY_LAST_PRI = 8'h55;
   localparam logic [7:0] KEY_LAST_ALT = 8'hAA;

   localparam logic [7:0] BASE_PRI = 8'h2E;
   localparam logic [7:0] BASE_ALT = 8'h4E;

   localparam logic [7:0] IX_EXIT    = 8'h02;
   localparam logic [7:0] IX_LDN     = 8'h07;
   localparam logic [7:0] IX_CHIPSEL = 8'h22;
   localparam logic [7:0] IX_SUSP    = 8'h23;
   localparam logic [7:0] IX_CLKSEL  = 8'h24;
   localparam logic [7:0] IX_ACT     = 8'h30;

   localparam logic [7:0] RD_FLOAT = 8'hFF;
   localparam logic [7:0] RD_EMPTY = 8'h00;

   function automatic logic [7:0] key_byte(input logic [1:0] step);
      case (step)
         2'd0:    key_byte = KEY_BYTE0;
         2'd1:    key_byte = KEY_BYTE1;
         default: key_byte = KEY_BYTE2;
      endcase
   endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              hit_pri,
   output logic              hit_alt
);
   localparam int STEP_W = $clog2(KEY_LEN);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

   logic [STEP_W-1:0] step_q, step_d;
   logic              key_wr;
   logic [STEP_W-1:0] restart;

   initial assert (ADDR_W >= 8) else $error("ADDR_W must be at least 8");

   assign key_wr  = armed && wr && (addr == ADDR_W'(BASE_PRI));
   assign restart = (wdata == KEY_BYTE0) ? STEP_W'(1) : '0;

   always_comb begin
      step_d  = step_q;
      hit_pri = 1'b0;
      hit_alt = 1'b0;
      if (!armed) begin
         step_d = '0;
      end else if (key_wr) begin
         if (step_q == LAST_STEP) begin
            if (wdata == KEY_LAST_PRI) begin
               hit_pri = 1'b1;
               step_d  = '0;
            end else if (wdata == KEY_LAST_ALT) begin
               hit_alt = 1'b1;
               step_d  = '0;
            end else begin
               step_d = restart;
            end
         end else if (wdata == key_byte(2'(step_q))) begin
            step_d = step_q + STEP_W'(1);
         end else begin
            step_d = restart;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end

   AST_KEY_BREAK_87: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && step_q != '0 && step_q != LAST_STEP && wdata == KEY_BYTE0
       && step_q != STEP_W'(1)) |=> (step_q == STEP_W'(1)))
      else $error("key restart on 0x87 failed"); // R4
endmodule

// File: rtl/sio_port_decode.sv
module sio_port_decode
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit ALT_BASE = 1'b1
) (
   input  logic              cfg_on,
   input  logic              base_alt,
   input  logic [ADDR_W-1:0] addr,
   output logic              idx_hit,
   output logic              dat_hit
);
   logic [ADDR_W-1:0] base;

   generate
      if (ALT_BASE) begin : g_two_bases
         assign base = base_alt ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);
      end else begin : g_one_base
         assign base = ADDR_W'(BASE_PRI);
      end
   endgenerate

   assign idx_hit = cfg_on && (addr == base);
   assign dat_hit = cfg_on && (addr == base + ADDR_W'(1));
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
   import sio_cfg_pkg::*;
#(
   parameter int NUM_DEV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               idx_hit,
   input  logic               dat_hit,
   input  logic [7:0]         wdata,
   input  logic               chip_strap,
   output logic [7:0]         rdata,
   output logic               exit_stb,
   output logic [NUM_DEV-1:0] dev_en,
   output logic               clk_sel,
   output logic               susp
);
   localparam int LDN_W = 8;

   logic [7:0]         idx_q;
   logic [LDN_W-1:0]   ldn_q;
   logic               csel_bit_q, csel_wr_q;
   logic               susp_q, clk_q;
   logic [NUM_DEV-1:0] act_q, act_nx;
   logic               accept, wr_idx, wr_dat, wr_ok, ldn_ok, act_sel;

   initial assert (NUM_DEV >= 1 && NUM_DEV <= 256)
      else $error("NUM_DEV out of range");

   assign accept = !csel_wr_q || (csel_bit_q == chip_strap);
   assign wr_idx = wr && idx_hit;
   assign wr_dat = wr && dat_hit;
   assign wr_ok  = wr_dat && accept;
   assign ldn_ok = {1'b0, ldn_q} < 9'(NUM_DEV);
   assign exit_stb = wr_dat && (idx_q == IX_EXIT) && wdata[1];

   generate
      for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
         assign act_nx[d] = (wr_ok && idx_q == IX_ACT && ldn_q == LDN_W'(d))
                            ? wdata[0] : act_q[d];
      end
   endgenerate

   always_comb begin
      act_sel = 1'b0;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (ldn_q == LDN_W'(d)) act_sel = act_q[d];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         ldn_q      <= '0;
         csel_bit_q <= 1'b0;
         csel_wr_q  <= 1'b0;
         susp_q     <= 1'b0;
         clk_q      <= 1'b0;
         act_q      <= '0;
      end else begin
         act_q <= act_nx;
         if (wr_idx) idx_q <= wdata;
         if (wr_dat && idx_q == IX_CHIPSEL) begin
            csel_bit_q <= wdata[7];
            csel_wr_q  <= 1'b1;
         end
         if (wr_ok && idx_q == IX_LDN)    ldn_q  <= wdata;
         if (wr_ok && idx_q == IX_SUSP)   susp_q <= wdata[0];
         if (wr_ok && idx_q == IX_CLKSEL) clk_q  <= wdata[0];
      end
   end

   always_comb begin
      rdata = RD_FLOAT;
      if (idx_hit) begin
         rdata = idx_q;
      end else if (dat_hit && accept) begin
         case (idx_q)
            IX_EXIT:    rdata = RD_FLOAT;
            IX_LDN:     rdata = ldn_q;
            IX_CHIPSEL: rdata = {csel_bit_q, 7'b0};
            IX_SUSP:    rdata = {7'b0, susp_q};
            IX_CLKSEL:  rdata = {7'b0, clk_q};
            IX_ACT:     rdata = ldn_ok ? {7'b0, act_sel} : RD_EMPTY;
            default:    rdata = RD_EMPTY;
         endcase
      end
   end

   assign dev_en  = act_q;
   assign clk_sel = clk_q;
   assign susp    = susp_q;

   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !idx_hit && !dat_hit) |=> ($stable(idx_q) && $stable(ldn_q)))
      else $error("register changed on unclaimed write"); // R5
   AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && csel_wr_q && csel_bit_q != chip_strap && idx_q != IX_CHIPSEL)
      |=> ($stable(ldn_q) && $stable(clk_q) && $stable(susp_q) && $stable(act_q)))
      else $error("foreign chip accepted a write"); // R10
   AST_BAD_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ldn_ok |=> $stable(act_q))
      else $error("enable changed with invalid device number"); // R7
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_DEV  = 4,
   parameter bit ALT_BASE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic               chip_strap,
   output logic [NUM_DEV-1:0] dev_enable,
   output logic               clk_sel_24m,
   output logic               soft_suspend,
   output logic               cfg_active
);
   logic cfg_on_q, base_alt_q;
   logic hit_pri, hit_alt, hit_alt_used;
   logic idx_hit, dat_hit, exit_stb;
   logic [7:0] reg_rdata;

   assign hit_alt_used = ALT_BASE ? hit_alt : 1'b0;

   sio_key_match #(.ADDR_W(ADDR_W)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (!cfg_on_q),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .hit_pri (hit_pri),
      .hit_alt (hit_alt)
   );

   sio_port_decode #(.ADDR_W(ADDR_W), .ALT_BASE(ALT_BASE)) u_dec (
      .cfg_on   (cfg_on_q),
      .base_alt (base_alt_q),
      .addr     (bus_addr),
      .idx_hit  (idx_hit),
      .dat_hit  (dat_hit)
   );

   sio_cfg_regs #(.NUM_DEV(NUM_DEV)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .idx_hit    (idx_hit),
      .dat_hit    (dat_hit),
      .wdata      (bus_wdata),
      .chip_strap (chip_strap),
      .rdata      (reg_rdata),
      .exit_stb   (exit_stb),
      .dev_en     (dev_enable),
      .clk_sel    (clk_sel_24m),
      .susp       (soft_suspend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_on_q   <= 1'b0;
         base_alt_q <= 1'b0;
      end else if (hit_pri || hit_alt_used) begin
         cfg_on_q   <= 1'b1;
         base_alt_q <= hit_alt_used;
      end else if (exit_stb) begin
         cfg_on_q <= 1'b0;
      end
   end

   assign bus_rdata  = (bus_rd && (idx_hit || dat_hit)) ? reg_rdata : RD_FLOAT;
   assign cfg_active = cfg_on_q;

   AST_UNLOCK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_pri || hit_alt_used) |=> cfg_on_q)
      else $error("key accepted but not unlocked"); // R2
   AST_ALT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_alt_used |=> base_alt_q)
      else $error("alternate key did not move base"); // R3
   AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      exit_stb |=> !cfg_on_q)
      else $error("exit command did not lock"); // R9
   AST_LOCKED_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_on_q && bus_rd) |-> (bus_rdata == RD_FLOAT))
      else $error("locked read returned data"); // R5
endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       chip_strap = 1'b0;
   logic [3:0] dev_enable;
   logic       clk_sel_24m, soft_suspend, cfg_active;
   int total = 0, bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sio_cfg_port u_sio_cfg_port (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .chip_strap (chip_strap), .dev_enable (dev_enable),
      .clk_sel_24m (clk_sel_24m), .soft_suspend (soft_suspend),
      .cfg_active (cfg_active)
   );

   // {is_read, port, write data, expected read}
   localparam int NV = 27;
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 8'h2E, 8'h87, 8'h00}, {1'b0, 8'h2E, 8'h01, 8'h00},
      {1'b0, 8'h2E, 8'h55, 8'h00}, {1'b0, 8'h2E, 8'h55, 8'h00},
      {1'b1, 8'h2E, 8'h00, 8'h00},
      {1'b0, 8'h2E, 8'h07, 8'h00}, {1'b0, 8'h2F, 8'h02, 8'h00},
      {1'b1, 8'h2F, 8'h00, 8'h02},
      {1'b0, 8'h2E, 8'h30, 8'h00}, {1'b0, 8'h2F, 8'h01, 8'h00},
      {1'b1, 8'h2F, 8'h00, 8'h01},
      {1'b0, 8'h2E, 8'h07, 8'h00}, {1'b0, 8'h2F, 8'h00, 8'h00},
      {1'b0, 8'h2E, 8'h30, 8'h00}, {1'b1, 8'h2F, 8'h00, 8'h00},
      {1'b0, 8'h2E, 8'h24, 8'h00}, {1'b0, 8'h2F, 8'hFF, 8'h00},
      {1'b1, 8'h2F, 8'h00, 8'h01},
      {1'b0, 8'h2E, 8'h23, 8'h00}, {1'b0, 8'h2F, 8'h01, 8'h00},
      {1'b1, 8'h2F, 8'h00, 8'h01},
      {1'b0, 8'h2E, 8'h55, 8'h00}, {1'b1, 8'h2F, 8'h00, 8'h00},
      {1'b0, 8'h2E, 8'h02, 8'h00}, {1'b1, 8'h2F, 8'h00, 8'hFF},
      {1'b0, 8'h2F, 8'h00, 8'h00}, {1'b1, 8'h2E, 8'h00, 8'h02}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr_op(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
      bus_rd = 1'b0;
   endtask

   task automatic key(input logic [7:0] last);
      wr_op(8'h2E, 8'h87); wr_op(8'h2E, 8'h01);
      wr_op(8'h2E, 8'h55); wr_op(8'h2E, last);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      chk("R1 cfg_active", {7'b0, cfg_active}, 8'h00);
      chk("R1 dev_enable", {4'b0, dev_enable}, 8'h00);
      chk("R1 clk/susp", {6'b0, clk_sel_24m, soft_suspend}, 8'h00);
      rd_chk(8'h2E, 8'hFF, "R1 index read");
      rd_chk(8'h2F, 8'hFF, "R1 data read");

      // vector table: R2 R6 R7 R8 R9 R11
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) rd_chk(VEC[i][23:16], VEC[i][7:0], "table R2/R6/R8/R9/R11");
         else            wr_op(VEC[i][23:16], VEC[i][15:8]);
      end
      chk("R8 enable dev2", {4'b0, dev_enable}, 8'h04);
      chk("R11 clk_sel", {7'b0, clk_sel_24m}, 8'h01);
      chk("R11 suspend", {7'b0, soft_suspend}, 8'h01);
      chk("R9 no exit on bit1 clear", {7'b0, cfg_active}, 8'h01);

      // R9 exit, R5 locked behaviour
      wr_op(8'h2F, 8'h02);
      #1 chk("R9 exit", {7'b0, cfg_active}, 8'h00);
      rd_chk(8'h2E, 8'hFF, "R5 locked index");
      rd_chk(8'h2F, 8'hFF, "R5 locked data");
      wr_op(8'h2E, 8'h07);
      wr_op(8'h2F, 8'h03);

      // R3 alternate base
      key(8'hAA);
      #1 chk("R3 unlocked", {7'b0, cfg_active}, 8'h01);
      rd_chk(8'h2E, 8'hFF, "R3 old index port");
      rd_chk(8'h2F, 8'hFF, "R3 old data port");
      rd_chk(8'h4E, 8'h02, "R5 index kept");
      wr_op(8'h4E, 8'h07);
      rd_chk(8'h4F, 8'h00, "R5 locked write ignored");
      wr_op(8'h4F, 8'h01);
      wr_op(8'h4E, 8'h30);
      wr_op(8'h4F, 8'h01);
      rd_chk(8'h4F, 8'h01, "R8 act dev1");
      #1 chk("R8 enable dev1", {4'b0, dev_enable}, 8'h06);

      // R7 out-of-range device number
      wr_op(8'h4E, 8'h07); wr_op(8'h4F, 8'h05);
      rd_chk(8'h4F, 8'h05, "R7 ldn readback");
      wr_op(8'h4E, 8'h30); wr_op(8'h4F, 8'h01);
      rd_chk(8'h4F, 8'h00, "R7 act bad ldn");
      #1 chk("R7 enables held", {4'b0, dev_enable}, 8'h06);
      wr_op(8'h4E, 8'h07); wr_op(8'h4F, 8'h01);
      wr_op(8'h4E, 8'h02); wr_op(8'h4F, 8'h02);
      #1 chk("R9 exit alt", {7'b0, cfg_active}, 8'h00);

      // R4 key restart
      wr_op(8'h2E, 8'h87); wr_op(8'h2E, 8'h01);
      key(8'h55);
      #1 chk("R4 restart on 87", {7'b0, cfg_active}, 8'h01);
      rd_chk(8'h2E, 8'h02, "R4 base 2E");
      wr_op(8'h2F, 8'h02);
      wr_op(8'h2E, 8'h87); wr_op(8'h2E, 8'h01); wr_op(8'h2E, 8'h12);
      wr_op(8'h2E, 8'h55); wr_op(8'h2E, 8'h55);
      #1 chk("R4 broken key", {7'b0, cfg_active}, 8'h00);
      rd_chk(8'h2E, 8'hFF, "R4 still locked");
      wr_op(8'h2E, 8'h87); wr_op(8'h80, 8'h00); wr_op(8'h2E, 8'h01);
      wr_op(8'h2E, 8'h55); wr_op(8'h2E, 8'h55);
      #1 chk("R4 other port ignored", {7'b0, cfg_active}, 8'h01);

      // R10 chip select
      wr_op(8'h2E, 8'h22); wr_op(8'h2F, 8'h80);
      wr_op(8'h2E, 8'h07); wr_op(8'h2F, 8'h03);
      rd_chk(8'h2F, 8'hFF, "R10 foreign read");
      rd_chk(8'h2E, 8'h07, "R10 index taken");
      wr_op(8'h2E, 8'h22); wr_op(8'h2F, 8'h00);
      rd_chk(8'h2F, 8'h00, "R10 chipsel read");
      wr_op(8'h2E, 8'h07);
      rd_chk(8'h2F, 8'h01, "R10 ldn unchanged");

      // R12 read and write in one cycle
      wr_op(8'h2E, 8'h30);
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h2F; bus_wdata = 8'h00;
      #1 chk("R12 read old value", bus_rdata, 8'h01);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      #1 chk("R12 write applied", {4'b0, dev_enable}, 8'h04);

      // R11 clear clock select
      wr_op(8'h2E, 8'h24); wr_op(8'h2F, 8'h00);
      #1 chk("R11 clk_sel cleared", {7'b0, clk_sel_24m}, 8'h00);

      // R9 bit1 clear then set
      wr_op(8'h2E, 8'h02); wr_op(8'h2F, 8'h01);
      #1 chk("R9 bit1 clear stays", {7'b0, cfg_active}, 8'h01);
      wr_op(8'h2F, 8'h02);
      #1 chk("R9 final exit", {7'b0, cfg_active}, 8'h00);

      finish_run();
   end
endmodule